// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns a virtual address into a physical address through a small fully associative store of page translations. Each entry holds a valid flag, a virtual page tag and a physical page tag. A lookup compares the virtual page tag against every entry at the same time. Each entry has a match line. The match line starts in the matching state and is cleared by any stored tag bit that differs from the key. An invalid entry never matches. A match line that is still set acts as the word-line enable for that entry's physical tag. When more than one line stays set, the lowest-indexed entry wins. The page-offset bits take no part in translation and pass straight through to the output.

The lookup key is captured in a register on the rising edge where `lk_valid_i` is high. Comparison and selection are combinational from that register. The hit flag and the physical address are registered on the next edge. Entries are loaded through a separate fill port. A fill can name an entry explicitly, or it can take the entry under a round-robin replacement pointer. The pointer advances only on pointer-directed fills.

Top module: `tlb_lookup`

## Requirements
- R1: After reset no entry is valid, the replacement pointer is 0, `lk_hit_o` is 0 and `lk_paddr_o` is 0.
- R2: A lookup presented with `lk_valid_i` high before rising edge N shows its result after rising edge N+1. On a hit, `lk_hit_o` is 1 and `lk_paddr_o` is {stored physical tag, offset}. The offset is the low OFF_W address bits, and the tag is the upper VA_W-OFF_W bits.
- R3: When several valid entries hold the searched virtual tag, the physical tag of the lowest-indexed one is returned.
- R4: The low OFF_W bits of `lk_paddr_o` equal the low OFF_W bits of the looked-up virtual address, on a hit and on a miss.
- R5: On a miss, `lk_hit_o` is 0 and the physical tag field of `lk_paddr_o` is all zeros.
- R6: An entry that has never been filled never matches, even when the key equals its reset tag value of zero.
- R7: A fill with `fill_use_idx_i` low writes the entry under the replacement pointer. The pointer then advances by one and wraps from ENTRIES-1 to 0, so successive such fills use entries 0, 1, …, ENTRIES-1, 0.
- R8: A fill with `fill_use_idx_i` high writes entry `fill_idx_i` and leaves the replacement pointer unchanged.
- R9: A fill replaces the previous contents of its entry. A lookup presented in any cycle after the fill sees the new translation, and the old virtual tag no longer matches that entry.
- R10: In a cycle whose registered key was not valid, the output shows `lk_hit_o` 0 and `lk_paddr_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | VA_W | Virtual address to translate |
| lk_hit_o | output | 1 | Registered hit flag |
| lk_paddr_o | output | PA_W | Registered physical address |
| fill_en_i | input | 1 | Load one entry |
| fill_use_idx_i | input | 1 | 1: use fill_idx_i; 0: use the replacement pointer |
| fill_idx_i | input | IDX_W | Explicit entry index |
| fill_vtag_i | input | VA_W-OFF_W | Virtual page tag to store |
| fill_ptag_i | input | PA_W-OFF_W | Physical page tag to store |

## Verification
A corrupted valid flag or stored tag shows up at the ports two edges after the next lookup of the affected page. It appears as a wrong hit flag or as a wrong physical tag. A replacement pointer that advances wrongly does not show at once. It appears only when a later pointer-directed fill overwrites the wrong entry, and a lookup then finds a stale or missing translation. The bench therefore wraps the pointer fully and mixes explicit fills with pointer fills before it probes. Priority errors appear only when duplicate tags exist, so the random tag pool is kept small on purpose.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TLB_MAX_ENTRIES = 256;
  typedef enum logic {FILL_RR = 1'b0, FILL_IDX = 1'b1} fill_mode_e;
endpackage

// File: rtl/tlb_cam_entry.sv
module tlb_cam_entry #(
  parameter int unsigned VTAG_W = 20,
  parameter int unsigned PTAG_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [VTAG_W-1:0] wvtag_i,
  input  logic [PTAG_W-1:0] wptag_i,
  input  logic [VTAG_W-1:0] key_i,
  output logic              vld_o,
  output logic              ml_o,
  output logic [PTAG_W-1:0] ptag_o
);
  logic              vld_q;
  logic [VTAG_W-1:0] vtag_q;
  logic [PTAG_W-1:0] ptag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      vtag_q <= '0;
      ptag_q <= '0;
    end else if (wr_i) begin
      vld_q  <= 1'b1;
      vtag_q <= wvtag_i;
      ptag_q <= wptag_i;
    end
  end

  // match line: starts set (gated by valid), any differing bit discharges it
  always_comb begin
    ml_o = vld_q;
    for (int b = 0; b < int'(VTAG_W); b++) begin
      if (vtag_q[b] != key_i[b]) ml_o = 1'b0;
    end
  end

  assign vld_o  = vld_q;
  assign ptag_o = ptag_q;
endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel #(
  parameter int unsigned N = 16,
  parameter int unsigned W = 20
) (
  input  logic [N-1:0]        ml_i,
  input  logic [N-1:0][W-1:0] data_i,
  output logic [N-1:0]        wl_o,
  output logic                hit_o,
  output logic [W-1:0]        data_o
);
  // scan high to low so the lowest index is assigned last and wins
  always_comb begin
    wl_o   = '0;
    data_o = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (ml_i[i]) begin
        wl_o    = '0;
        wl_o[i] = 1'b1;
        data_o  = data_i[i];
      end
    end
  end

  assign hit_o = |ml_i;
endmodule

// File: rtl/tlb_repl_ptr.sv
module tlb_repl_ptr #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned OFF_W   = 12,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned VTAG_W = VA_W - OFF_W,
  localparam int unsigned PTAG_W = PA_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [VA_W-1:0]   lk_vaddr_i,
  output logic              lk_hit_o,
  output logic [PA_W-1:0]   lk_paddr_o,
  input  logic              fill_en_i,
  input  logic              fill_use_idx_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [VTAG_W-1:0] fill_vtag_i,
  input  logic [PTAG_W-1:0] fill_ptag_i
);
  initial begin
    if (ENTRIES > TLB_MAX_ENTRIES || ENTRIES < 1) $error("ENTRIES out of range");
  end

  logic                         key_vld_q;
  logic [VA_W-1:0]              key_q;
  logic [ENTRIES-1:0]           vld;
  logic [ENTRIES-1:0]           ml;
  logic [ENTRIES-1:0]           wl;
  logic [ENTRIES-1:0][PTAG_W-1:0] ptag;
  logic [PTAG_W-1:0]            sel_ptag;
  logic                         any_hit;
  logic [IDX_W-1:0]             ptr;
  logic [IDX_W-1:0]             wr_idx;
  fill_mode_e                   fill_mode;

  assign fill_mode = fill_use_idx_i ? FILL_IDX : FILL_RR;
  assign wr_idx    = (fill_mode == FILL_IDX) ? fill_idx_i : ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_vld_q <= 1'b0;
      key_q     <= '0;
    end else begin
      key_vld_q <= lk_valid_i;
      if (lk_valid_i) key_q <= lk_vaddr_i;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    tlb_cam_entry #(.VTAG_W(VTAG_W), .PTAG_W(PTAG_W)) i_ent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (fill_en_i && (wr_idx == IDX_W'(g))),
      .wvtag_i (fill_vtag_i),
      .wptag_i (fill_ptag_i),
      .key_i   (key_q[VA_W-1:OFF_W]),
      .vld_o   (vld[g]),
      .ml_o    (ml[g]),
      .ptag_o  (ptag[g])
    );
  end

  tlb_prio_sel #(.N(ENTRIES), .W(PTAG_W)) i_sel (
    .ml_i   (ml),
    .data_i (ptag),
    .wl_o   (wl),
    .hit_o  (any_hit),
    .data_o (sel_ptag)
  );

  tlb_repl_ptr #(.N(ENTRIES), .IDX_W(IDX_W)) i_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (fill_en_i && (fill_mode == FILL_RR)),
    .ptr_o  (ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_hit_o   <= 1'b0;
      lk_paddr_o <= '0;
    end else if (key_vld_q) begin
      lk_hit_o   <= any_hit;
      lk_paddr_o <= {(any_hit ? sel_ptag : PTAG_W'(0)), key_q[OFF_W-1:0]};
    end else begin
      lk_hit_o   <= 1'b0;
      lk_paddr_o <= '0;
    end
  end
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned IDX_W   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fill_en_i,
  input logic               fill_use_idx_i,
  input logic               lk_hit_o,
  input logic [PA_W-1:0]    lk_paddr_o,
  input logic               key_vld_q,
  input logic [VA_W-1:0]    key_q,
  input logic [ENTRIES-1:0] vld,
  input logic [ENTRIES-1:0] ml,
  input logic [ENTRIES-1:0] wl,
  input logic [IDX_W-1:0]   ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  a_r6_invalid_no_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ml & ~vld) == '0);

  a_r3_single_wordline: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wl));

  a_r4_offset_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_vld_q |=> lk_paddr_o[OFF_W-1:0] == $past(key_q[OFF_W-1:0]));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_vld_q |=> !lk_hit_o && lk_paddr_o == '0);

  a_r5_miss_zero_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_vld_q && ml == '0 |=> !lk_hit_o && lk_paddr_o[PA_W-1:OFF_W] == '0);

  a_r7_ptr_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i && !fill_use_idx_i |=>
      ptr == (($past(ptr) == LAST) ? IDX_W'(0) : IDX_W'($past(ptr) + 1'b1)));

  a_r8_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_en_i && !fill_use_idx_i) |=> $stable(ptr));
endmodule

bind tlb_lookup tlb_lookup_chk #(
  .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .fill_en_i      (fill_en_i),
  .fill_use_idx_i (fill_use_idx_i),
  .lk_hit_o       (lk_hit_o),
  .lk_paddr_o     (lk_paddr_o),
  .key_vld_q      (key_vld_q),
  .key_q          (key_q),
  .vld            (vld),
  .ml             (ml),
  .wl             (wl),
  .ptr            (ptr)
);

// File: tb/test_tlb_lookup.sv
module test_tlb_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int N      = 16;
  localparam int VA_W   = 32;
  localparam int PA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 4;
  localparam int VTAG_W = VA_W - OFF_W;
  localparam int PTAG_W = PA_W - OFF_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              lk_valid_i = 1'b0;
  logic [VA_W-1:0]   lk_vaddr_i = '0;
  logic              lk_hit_o;
  logic [PA_W-1:0]   lk_paddr_o;
  logic              fill_en_i = 1'b0;
  logic              fill_use_idx_i = 1'b0;
  logic [IDX_W-1:0]  fill_idx_i = '0;
  logic [VTAG_W-1:0] fill_vtag_i = '0;
  logic [PTAG_W-1:0] fill_ptag_i = '0;

  int n_chk = 0;
  int n_bad = 0;

  logic              m_vld [N];
  logic [VTAG_W-1:0] m_vtag[N];
  logic [PTAG_W-1:0] m_ptag[N];
  int                m_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_lookup #(.ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) i_tlb_lookup (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid_i), .lk_vaddr_i(lk_vaddr_i),
    .lk_hit_o(lk_hit_o), .lk_paddr_o(lk_paddr_o),
    .fill_en_i(fill_en_i), .fill_use_idx_i(fill_use_idx_i), .fill_idx_i(fill_idx_i),
    .fill_vtag_i(fill_vtag_i), .fill_ptag_i(fill_ptag_i)
  );

  function automatic logic [PA_W:0] expect_of(input logic [VA_W-1:0] va);
    for (int i = 0; i < N; i++) begin
      if (m_vld[i] && m_vtag[i] == va[VA_W-1:OFF_W])
        return {1'b1, m_ptag[i], va[OFF_W-1:0]};
    end
    return {1'b0, {PTAG_W{1'b0}}, va[OFF_W-1:0]};
  endfunction

  task automatic check(input string req, input logic [PA_W:0] act, input logic [PA_W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual hit/paddr=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fill(input bit use_idx, input int idx, input logic [VTAG_W-1:0] vt,
                         input logic [PTAG_W-1:0] pt);
    int tgt;
    @(negedge clk);
    fill_en_i = 1'b1; fill_use_idx_i = use_idx; fill_idx_i = IDX_W'(idx);
    fill_vtag_i = vt; fill_ptag_i = pt;
    @(posedge clk);
    @(negedge clk);
    fill_en_i = 1'b0;
    tgt = use_idx ? idx : m_ptr;
    m_vld[tgt] = 1'b1; m_vtag[tgt] = vt; m_ptag[tgt] = pt;
    if (!use_idx) m_ptr = (m_ptr + 1) % N;
  endtask

  // lookup launched on a falling edge; result valid after the second rising edge
  task automatic do_lookup(input string req, input logic [VA_W-1:0] va);
    @(negedge clk);
    lk_valid_i = 1'b1; lk_vaddr_i = va;
    @(posedge clk);
    @(negedge clk);
    lk_valid_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(req, {lk_hit_o, lk_paddr_o}, expect_of(va));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 1'b0; m_vtag[i] = '0; m_ptag[i] = '0;
    end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1", {lk_hit_o, lk_paddr_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", {lk_hit_o, lk_paddr_o}, '0);

    // R6: empty entries have zero tags but must not match key tag 0
    do_lookup("R6", 32'h0000_0abc);
    check("R6", {lk_hit_o, 32'h0}, '0);

    // R7: pointer fills wrap through all entries and back to 0
    for (int i = 0; i <= N; i++) do_fill(1'b0, 0, VTAG_W'(32'h200 + i), PTAG_W'(32'h5000 + i));
    do_lookup("R7", {VTAG_W'(32'h200), 12'h123});
    check("R7", {lk_hit_o, 32'h0}, '0);
    do_lookup("R7", {VTAG_W'(32'h200 + N), 12'h456});
    check("R7", {lk_hit_o, lk_paddr_o}, {1'b1, PTAG_W'(32'h5000 + N), 12'h456});
    do_lookup("R2", {VTAG_W'(32'h205), 12'hfff});

    // R8: explicit fills, then a pointer fill lands at entry 1
    do_fill(1'b1, 9, VTAG_W'(32'h777), PTAG_W'(32'h0a09));
    do_fill(1'b1, 3, VTAG_W'(32'h777), PTAG_W'(32'h0a03));
    do_fill(1'b0, 0, VTAG_W'(32'h888), PTAG_W'(32'h0b01));
    do_lookup("R8", {VTAG_W'(32'h201), 12'h010});
    check("R8", {lk_hit_o, 32'h0}, '0);
    do_lookup("R8", {VTAG_W'(32'h888), 12'h010});
    check("R8", {lk_hit_o, lk_paddr_o}, {1'b1, PTAG_W'(32'h0b01), 12'h010});

    // R3: duplicate tags at 3 and 9, lowest wins
    do_lookup("R3", {VTAG_W'(32'h777), 12'h001});
    check("R3", {lk_hit_o, lk_paddr_o}, {1'b1, PTAG_W'(32'h0a03), 12'h001});

    // R9: overwrite entry 3 with another tag; entry 9 now serves 0x777
    do_fill(1'b1, 3, VTAG_W'(32'h999), PTAG_W'(32'h0c03));
    do_lookup("R9", {VTAG_W'(32'h777), 12'h002});
    check("R9", {lk_hit_o, lk_paddr_o}, {1'b1, PTAG_W'(32'h0a09), 12'h002});
    do_lookup("R9", {VTAG_W'(32'h999), 12'h003});

    // R5 and R4: miss keeps offset, zeros tag
    do_lookup("R5", 32'hdead_beef);
    check("R4", {1'b0, lk_paddr_o[OFF_W-1:0]}, {1'b0, 20'h0, 12'heef});

    // R10: idle cycle after a hit returns to zero
    do_lookup("R10", {VTAG_W'(32'h888), 12'h3c3});
    @(negedge clk);
    check("R10", {lk_hit_o, lk_paddr_o}, '0);

    // random mix (R2, R3, R4, R5, R7, R8, R9)
    for (int k = 0; k < 400; k++) begin
      logic [VTAG_W-1:0] vt;
      vt = VTAG_W'(32'h300 + ($urandom % 24));
      if ($urandom % 4 == 0)
        do_fill(1'($urandom % 2), int'($urandom % N), vt, PTAG_W'($urandom));
      else
        do_lookup("R2", {vt, 12'($urandom)});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule